// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block produces the line and field structure of an analog component video signal, one word per pixel clock. A horizontal pixel counter and a frame line counter run freely from the pixel clock and are pulled into step by a horizontal and a vertical reference. The reference comes either from dedicated horizontal, vertical and field-ID pins or from flags that an upstream decoder has already pulled out of embedded timing codes; one select pin picks the source. Inside the active window the incoming picture word passes straight through. Everywhere else the block outputs a blank, negative-sync or positive-sync level word, and each of these three levels comes from a register.

Two sync styles are supported. Standard definition uses bi-level sync, with equalizing pulses on the lines before and after the vertical sync and serrated lines in between. High definition uses tri-level sync at the start of every line, and broad pulses on the vertical sync lines. All horizontal edges, all vertical line numbers, the frame length and the start of the second field are configuration inputs. Interlaced operation splits the frame into two fields. Vertical line numbers are counted from the top of each field.

There is no handshake. The output word is valid on every clock, and it depends only on the counter state, the configuration and the picture word presented in that cycle.

Top module: `vsync_tgen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, h_pos and v_pos are 0.
- R2: Without a reference edge, h_pos advances by 1 per clock. When h_pos+1 reaches cfg_line_len, h_pos returns to 0 and v_pos advances by 1. When v_pos+1 reaches cfg_frame_lines, v_pos returns to 0 instead.
- R3: src_sel=0 takes hs_in, vs_in and fid_in as the reference, and src_sel=1 takes emb_h, emb_v and emb_f. The unselected set has no effect on any output.
- R4: A rising edge on the selected horizontal reference (high now, low in the previous cycle) sets h_pos to 0 at the next clock and advances v_pos with the same frame wrap as R2.
- R5: A rising edge on the selected vertical reference sets h_pos to 0 at the next clock. It sets v_pos to cfg_f2_start if the selected field ID is 1, and to 0 if it is 0. A vertical edge takes priority over a horizontal edge in the same cycle.
- R6: The field line is v_pos, or v_pos minus cfg_f2_start in field 1. With hd_mode=0 on a plain line, the output is the negative sync level for h_pos < sync width and the blank level otherwise.
- R7: With hd_mode=0, lines in [cfg_v_pre, cfg_v_ser) and [cfg_v_post, cfg_v_end) are equalizing lines. They carry negative sync for h_pos < sw/2 and for half ≤ h_pos < half+sw/2, where half = line_len/2 (integer division throughout), and blank elsewhere.
- R8: With hd_mode=0, lines in [cfg_v_ser, cfg_v_post) are serrated. They carry negative sync, except that they return to blank in [half−sw, half) and in [line_len−sw, line_len).
- R9: With hd_mode=1, every line starts with negative sync for h_pos < sw, then positive sync for sw ≤ h_pos < 2·sw, and is blank after that. The equalizing ranges have no effect in this mode.
- R10: With hd_mode=1, lines in [cfg_v_ser, cfg_v_post) are broad-pulse lines. They carry the tri-level start of R9, then negative sync from 2·sw up to half, then blank.
- R11: h_blank is low exactly when sw+bporch ≤ h_pos < sw+bporch+act_w. v_blank is low exactly when cfg_act_first ≤ field line ≤ cfg_act_last. active is high exactly when both are low, and then vid_out equals vid_in.
- R12: field is 1 exactly when interlace=1 and v_pos ≥ cfg_f2_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 1 | Reference source: 0 dedicated pins, 1 embedded flags |
| hs_in | input | 1 | Dedicated horizontal reference |
| vs_in | input | 1 | Dedicated vertical reference |
| fid_in | input | 1 | Dedicated field ID |
| emb_h | input | 1 | Horizontal flag decoded from embedded codes |
| emb_v | input | 1 | Vertical flag decoded from embedded codes |
| emb_f | input | 1 | Field flag decoded from embedded codes |
| hd_mode | input | 1 | 0 bi-level SD sync, 1 tri-level HD sync |
| interlace | input | 1 | Two fields per frame |
| cfg_line_len | input | 12 | Pixels per line |
| cfg_sync_w | input | 12 | Sync pulse width in pixels |
| cfg_bporch | input | 12 | Back porch width in pixels |
| cfg_act_w | input | 12 | Active pixels per line |
| cfg_frame_lines | input | 11 | Lines per frame |
| cfg_f2_start | input | 11 | First frame line of field 1 |
| cfg_v_pre | input | 11 | First pre-equalizing field line |
| cfg_v_ser | input | 11 | First serrated / broad field line |
| cfg_v_post | input | 11 | First post-equalizing field line |
| cfg_v_end | input | 11 | Field line after the last equalizing line |
| cfg_act_first | input | 11 | First active field line |
| cfg_act_last | input | 11 | Last active field line |
| lvl_blank | input | 10 | Blank level word |
| lvl_nsync | input | 10 | Negative sync level word |
| lvl_psync | input | 10 | Positive sync level word |
| vid_in | input | 10 | Picture word |
| vid_out | output | 10 | Output word to the converters |
| active | output | 1 | Active picture region |
| h_blank | output | 1 | Horizontal blanking region |
| v_blank | output | 1 | Vertical blanking region |
| field | output | 1 | Current field |
| h_pos | output | 12 | Pixel counter |
| v_pos | output | 11 | Frame line counter |

## Verification
The assertions check on every clock that the counters obey their update rules. A horizontal edge zeroes the pixel counter, and a vertical edge loads the field start selected by the field ID. With no edge the counter steps by one, and the frame wraps to line 0. A progressive frame never raises the field flag. The level words on each kind of line, the pulse positions at half-line points, the active window, and the fact that the unselected reference has no effect depend on configuration and history over whole lines and frames. Only the bench scenarios show those: they compare every output against a model built from the requirements, in both modes and with both sources.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  // Kind of line being drawn, chosen from the field line number and the mode.
  typedef enum logic [1:0] {
    LK_PLAIN = 2'd0,
    LK_EQUAL = 2'd1,
    LK_SERR  = 2'd2,
    LK_BROAD = 2'd3
  } line_kind_e;
endpackage

// File: rtl/vtg_ref_sel.sv
module vtg_ref_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic hs_in,
  input  logic vs_in,
  input  logic fid_in,
  input  logic emb_h,
  input  logic emb_v,
  input  logic emb_f,
  output logic h_edge,
  output logic v_edge,
  output logic f_sel
);
  logic h_sel, v_sel;
  logic h_q, v_q;

  // Source mux: only the chosen set reaches the edge detectors
  assign h_sel = src_sel ? emb_h : hs_in;
  assign v_sel = src_sel ? emb_v : vs_in;
  assign f_sel = src_sel ? emb_f : fid_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= 1'b0;
      v_q <= 1'b0;
    end else begin
      h_q <= h_sel;
      v_q <= v_sel;
    end
  end

  assign h_edge = h_sel & ~h_q;
  assign v_edge = v_sel & ~v_q;
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_edge,
  input  logic          v_edge,
  input  logic          f_sel,
  input  logic          interlace,
  input  logic [HW-1:0] cfg_line_len,
  input  logic [VW-1:0] cfg_frame_lines,
  input  logic [VW-1:0] cfg_f2_start,
  output logic [HW-1:0] px,
  output logic [VW-1:0] line,
  output logic [VW-1:0] fline,
  output logic          field
);
  logic [HW:0] px_nx;
  logic [VW:0] line_nx;
  logic        px_wrap, line_wrap;
  logic [VW-1:0] line_adv;

  assign px_nx     = {1'b0, px} + {{HW{1'b0}}, 1'b1};
  assign line_nx   = {1'b0, line} + {{VW{1'b0}}, 1'b1};
  assign px_wrap   = px_nx >= {1'b0, cfg_line_len};
  assign line_wrap = line_nx >= {1'b0, cfg_frame_lines};
  assign line_adv  = line_wrap ? '0 : line_nx[VW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px   <= '0;
      line <= '0;
    end else if (v_edge) begin
      px   <= '0;
      line <= f_sel ? cfg_f2_start : '0;
    end else if (h_edge || px_wrap) begin
      px   <= '0;
      line <= line_adv;
    end else begin
      px   <= px_nx[HW-1:0];
    end
  end

  assign field = interlace && (line >= cfg_f2_start);
  assign fline = field ? (line - cfg_f2_start) : line;

  assert_hlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_edge && !v_edge) |=> (px == '0));

  assert_vlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    v_edge |=> (px == '0) && (line == ($past(f_sel) ? $past(cfg_f2_start) : '0)));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_edge && !v_edge && (px_nx < {1'b0, cfg_line_len})) |=> (px == $past(px) + 1'b1));

  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_edge && px_wrap && line_wrap) |=> (line == '0));

  assert_progressive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !interlace |-> !field);
endmodule

// File: rtl/vtg_level.sv
module vtg_level
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int DW = 10
) (
  input  logic [HW-1:0] px,
  input  logic [VW-1:0] fline,
  input  logic          hd_mode,
  input  logic [HW-1:0] cfg_line_len,
  input  logic [HW-1:0] cfg_sync_w,
  input  logic [HW-1:0] cfg_bporch,
  input  logic [HW-1:0] cfg_act_w,
  input  logic [VW-1:0] cfg_v_pre,
  input  logic [VW-1:0] cfg_v_ser,
  input  logic [VW-1:0] cfg_v_post,
  input  logic [VW-1:0] cfg_v_end,
  input  logic [VW-1:0] cfg_act_first,
  input  logic [VW-1:0] cfg_act_last,
  input  logic [DW-1:0] lvl_blank,
  input  logic [DW-1:0] lvl_nsync,
  input  logic [DW-1:0] lvl_psync,
  input  logic [DW-1:0] vid_in,
  output logic [DW-1:0] vid_out,
  output logic          active,
  output logic          h_blank,
  output logic          v_blank
);
  localparam int CW = HW + 1;

  logic [CW-1:0] p, len, half, sw, sw_half, sw_dbl, act_beg, act_end;
  logic          in_pre, in_mid, in_post;
  line_kind_e    kind;
  logic [DW-1:0] lvl;

  assign p       = {1'b0, px};
  assign len     = {1'b0, cfg_line_len};
  assign half    = len >> 1;
  assign sw      = {1'b0, cfg_sync_w};
  assign sw_half = sw >> 1;
  assign sw_dbl  = sw << 1;
  assign act_beg = sw + {1'b0, cfg_bporch};
  assign act_end = act_beg + {1'b0, cfg_act_w};

  assign in_pre  = (fline >= cfg_v_pre)  && (fline < cfg_v_ser);
  assign in_mid  = (fline >= cfg_v_ser)  && (fline < cfg_v_post);
  assign in_post = (fline >= cfg_v_post) && (fline < cfg_v_end);

  always_comb begin
    kind = LK_PLAIN;
    if (hd_mode) begin
      if (in_mid) kind = LK_BROAD;
    end else if (in_mid) begin
      kind = LK_SERR;
    end else if (in_pre || in_post) begin
      kind = LK_EQUAL;
    end
  end

  always_comb begin
    lvl = lvl_blank;
    case (kind)
      LK_PLAIN: begin
        if (p < sw) lvl = lvl_nsync;
        else if (hd_mode && (p < sw_dbl)) lvl = lvl_psync;
      end
      LK_EQUAL: begin
        if ((p < sw_half) || ((p >= half) && (p < half + sw_half))) lvl = lvl_nsync;
      end
      LK_SERR: begin
        lvl = lvl_nsync;
        if (((p >= half - sw) && (p < half)) || ((p >= len - sw) && (p < len)))
          lvl = lvl_blank;
      end
      LK_BROAD: begin
        if (p < sw) lvl = lvl_nsync;
        else if (p < sw_dbl) lvl = lvl_psync;
        else if (p < half) lvl = lvl_nsync;
      end
      default: lvl = lvl_blank;
    endcase
  end

  assign h_blank = !((p >= act_beg) && (p < act_end));
  assign v_blank = !((fline >= cfg_act_first) && (fline <= cfg_act_last));
  assign active  = !h_blank && !v_blank;
  assign vid_out = active ? vid_in : lvl;
endmodule

// File: rtl/vsync_tgen.sv
module vsync_tgen #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_sel,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic          fid_in,
  input  logic          emb_h,
  input  logic          emb_v,
  input  logic          emb_f,
  input  logic          hd_mode,
  input  logic          interlace,
  input  logic [HW-1:0] cfg_line_len,
  input  logic [HW-1:0] cfg_sync_w,
  input  logic [HW-1:0] cfg_bporch,
  input  logic [HW-1:0] cfg_act_w,
  input  logic [VW-1:0] cfg_frame_lines,
  input  logic [VW-1:0] cfg_f2_start,
  input  logic [VW-1:0] cfg_v_pre,
  input  logic [VW-1:0] cfg_v_ser,
  input  logic [VW-1:0] cfg_v_post,
  input  logic [VW-1:0] cfg_v_end,
  input  logic [VW-1:0] cfg_act_first,
  input  logic [VW-1:0] cfg_act_last,
  input  logic [DW-1:0] lvl_blank,
  input  logic [DW-1:0] lvl_nsync,
  input  logic [DW-1:0] lvl_psync,
  input  logic [DW-1:0] vid_in,
  output logic [DW-1:0] vid_out,
  output logic          active,
  output logic          h_blank,
  output logic          v_blank,
  output logic          field,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos
);
  logic          h_edge, v_edge, f_sel;
  logic [VW-1:0] fline;

  vtg_ref_sel u_ref (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .hs_in(hs_in), .vs_in(vs_in), .fid_in(fid_in),
    .emb_h(emb_h), .emb_v(emb_v), .emb_f(emb_f),
    .h_edge(h_edge), .v_edge(v_edge), .f_sel(f_sel)
  );

  vtg_counters #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .h_edge(h_edge), .v_edge(v_edge), .f_sel(f_sel),
    .interlace(interlace), .cfg_line_len(cfg_line_len),
    .cfg_frame_lines(cfg_frame_lines), .cfg_f2_start(cfg_f2_start),
    .px(h_pos), .line(v_pos), .fline(fline), .field(field)
  );

  vtg_level #(.HW(HW), .VW(VW), .DW(DW)) u_lvl (
    .px(h_pos), .fline(fline), .hd_mode(hd_mode),
    .cfg_line_len(cfg_line_len), .cfg_sync_w(cfg_sync_w),
    .cfg_bporch(cfg_bporch), .cfg_act_w(cfg_act_w),
    .cfg_v_pre(cfg_v_pre), .cfg_v_ser(cfg_v_ser), .cfg_v_post(cfg_v_post),
    .cfg_v_end(cfg_v_end), .cfg_act_first(cfg_act_first), .cfg_act_last(cfg_act_last),
    .lvl_blank(lvl_blank), .lvl_nsync(lvl_nsync), .lvl_psync(lvl_psync),
    .vid_in(vid_in), .vid_out(vid_out), .active(active),
    .h_blank(h_blank), .v_blank(v_blank)
  );
endmodule

// File: tb/vsync_tgen_test.sv
module vsync_tgen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sel = 0, hs_in = 0, vs_in = 0, fid_in = 0, emb_h = 0, emb_v = 0, emb_f = 0;
  logic hd_mode = 0, interlace = 0;
  logic [9:0] vid_in = '0;
  int c_len, c_sw, c_bp, c_aw, c_frame, c_f2, c_pre, c_ser, c_post, c_end, c_af, c_al;
  int c_blank, c_nsync, c_psync;
  logic [9:0]  vid_out;
  logic        active, h_blank, v_blank, field;
  logic [11:0] h_pos;
  logic [10:0] v_pos;

  int n_chk = 0, n_err = 0;
  int m_px, m_line;
  bit m_ph, m_pv;
  string pos_tag;

  always #10 clk = ~clk;

  vsync_tgen uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .hs_in(hs_in), .vs_in(vs_in), .fid_in(fid_in),
    .emb_h(emb_h), .emb_v(emb_v), .emb_f(emb_f),
    .hd_mode(hd_mode), .interlace(interlace),
    .cfg_line_len(12'(c_len)), .cfg_sync_w(12'(c_sw)), .cfg_bporch(12'(c_bp)),
    .cfg_act_w(12'(c_aw)), .cfg_frame_lines(11'(c_frame)), .cfg_f2_start(11'(c_f2)),
    .cfg_v_pre(11'(c_pre)), .cfg_v_ser(11'(c_ser)), .cfg_v_post(11'(c_post)),
    .cfg_v_end(11'(c_end)), .cfg_act_first(11'(c_af)), .cfg_act_last(11'(c_al)),
    .lvl_blank(10'(c_blank)), .lvl_nsync(10'(c_nsync)), .lvl_psync(10'(c_psync)),
    .vid_in(vid_in), .vid_out(vid_out), .active(active),
    .h_blank(h_blank), .v_blank(v_blank), .field(field),
    .h_pos(h_pos), .v_pos(v_pos)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d (h=%0d v=%0d)", tag, act, exp, m_px, m_line);
    end
  endtask

  // 0 plain, 1 equalizing, 2 serrated, 3 broad
  function automatic int line_kind(input int fl);
    bit mid = (fl >= c_ser) && (fl < c_post);
    bit eq  = ((fl >= c_pre) && (fl < c_ser)) || ((fl >= c_post) && (fl < c_end));
    if (hd_mode) return mid ? 3 : 0;
    if (mid) return 2;
    return eq ? 1 : 0;
  endfunction

  function automatic int exp_level(input int kind, input int p);
    int half = c_len / 2;
    case (kind)
      1: return ((p < c_sw/2) || (p >= half && p < half + c_sw/2)) ? c_nsync : c_blank;
      2: return (((p >= half - c_sw) && (p < half)) || ((p >= c_len - c_sw) && (p < c_len)))
                ? c_blank : c_nsync;
      3: begin
           if (p < c_sw) return c_nsync;
           if (p < 2*c_sw) return c_psync;
           return (p < half) ? c_nsync : c_blank;
         end
      default: begin
           if (p < c_sw) return c_nsync;
           if (hd_mode && p < 2*c_sw) return c_psync;
           return c_blank;
         end
    endcase
  endfunction

  task automatic check_all();
    bit fld = interlace && (m_line >= c_f2);
    int fl = fld ? m_line - c_f2 : m_line;
    bit hb = !((m_px >= c_sw + c_bp) && (m_px < c_sw + c_bp + c_aw));
    bit vb = !((fl >= c_af) && (fl <= c_al));
    bit act = !hb && !vb;
    int kind = line_kind(fl);
    string wtag;
    chk(pos_tag, int'(h_pos), m_px);
    chk(pos_tag, int'(v_pos), m_line);
    chk("R11 h_blank", int'(h_blank), int'(hb));
    chk("R11 v_blank", int'(v_blank), int'(vb));
    chk("R11 active", int'(active), int'(act));
    chk("R12 field", int'(field), int'(fld));
    if (act) wtag = "R11 word";
    else if (hd_mode) wtag = (kind == 3) ? "R10 word" : "R9 word";
    else wtag = (kind == 1) ? "R7 word" : (kind == 2) ? "R8 word" : "R6 word";
    chk(wtag, int'(vid_out), act ? int'(vid_in) : exp_level(kind, m_px));
  endtask

  task automatic advance();
    bit h = src_sel ? emb_h : hs_in;
    bit v = src_sel ? emb_v : vs_in;
    bit f = src_sel ? emb_f : fid_in;
    bit he = h && !m_ph;
    bit ve = v && !m_pv;
    if (ve) begin
      m_px = 0; m_line = f ? c_f2 : 0;
      pos_tag = src_sel ? "R3 pos(R5)" : "R5 pos";
    end else if (he || (m_px + 1 >= c_len)) begin
      m_px = 0; m_line = (m_line + 1 >= c_frame) ? 0 : m_line + 1;
      pos_tag = he ? (src_sel ? "R3 pos(R4)" : "R4 pos") : "R2 pos";
    end else begin
      m_px++;
      pos_tag = "R2 pos";
    end
    m_ph = h; m_pv = v;
  endtask

  task automatic new_cfg(input bit hd, input bit il);
    hd_mode = hd; interlace = il;
    c_len = 48 + int'($urandom % 48);
    c_sw  = 3 + int'($urandom % 5);
    c_bp  = 2 + int'($urandom % 4);
    c_aw  = c_len - c_sw - c_bp - 2 - int'($urandom % 4);
    c_frame = 16 + int'($urandom % 9);
    c_f2  = c_frame / 2;
    c_pre = 1;
    c_ser = c_pre + 1 + int'($urandom % 2);
    c_post = c_ser + 1 + int'($urandom % 2);
    c_end = c_post + 1 + int'($urandom % 2);
    c_af  = c_end;
    c_al  = (il ? c_f2 : c_frame) - 2;
    c_blank = 200 + int'($urandom % 100);
    c_nsync = 4 + int'($urandom % 60);
    c_psync = 500 + int'($urandom % 300);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    hs_in = 0; vs_in = 0; fid_in = 0; emb_h = 0; emb_v = 0; emb_f = 0;
    repeat (3) @(negedge clk);
    m_px = 0; m_line = 0; m_ph = 0; m_pv = 0;
    pos_tag = "R1 pos";
    #1;
    chk("R1 reset h_pos", int'(h_pos), 0);
    chk("R1 reset v_pos", int'(v_pos), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all();
    advance();
  endtask

  // hrate/vrate: one-in-N chance of a reference pulse per cycle, 0 for none
  task automatic run_phase(input int cycles, input bit src, input int hrate, input int vrate);
    bit hp, vp, fp;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      src_sel = src;
      vid_in = 10'($urandom);
      hp = (hrate > 0) && (($urandom % hrate) == 0);
      vp = (vrate > 0) && (($urandom % vrate) == 0);
      fp = 1'($urandom);
      if (!src) begin
        hs_in = hp; vs_in = vp; fid_in = fp;
        emb_h = 1'($urandom); emb_v = 1'($urandom); emb_f = 1'($urandom);
      end else begin
        emb_h = hp; emb_v = vp; emb_f = fp;
        hs_in = 1'($urandom); vs_in = 1'($urandom); fid_in = 1'($urandom);
      end
      #1;
      check_all();
      advance();
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    // SD progressive, free running, dedicated pins idle
    new_cfg(1'b0, 1'b0); do_reset(); run_phase(3 * c_len * c_frame, 1'b0, 0, 0);
    // SD interlaced, dedicated pins with H and V pulses, embedded noise ignored
    new_cfg(1'b0, 1'b1); do_reset(); run_phase(4 * c_len * c_frame, 1'b0, 97, 900);
    // SD interlaced, embedded source, dedicated noise ignored
    new_cfg(1'b0, 1'b1); do_reset(); run_phase(4 * c_len * c_frame, 1'b1, 89, 800);
    // HD progressive free run
    new_cfg(1'b1, 1'b0); do_reset(); run_phase(3 * c_len * c_frame, 1'b0, 0, 0);
    // HD interlaced, embedded source with pulses
    new_cfg(1'b1, 1'b1); do_reset(); run_phase(4 * c_len * c_frame, 1'b1, 101, 700);
    // Directed: simultaneous H and V edge with field ID 1 (V wins, R5)
    new_cfg(1'b0, 1'b1); do_reset(); run_phase(30, 1'b0, 0, 0);
    @(negedge clk);
    src_sel = 0; hs_in = 1; vs_in = 1; fid_in = 1; emb_h = 0; emb_v = 0; emb_f = 0;
    #1; check_all(); advance();
    @(negedge clk);
    hs_in = 0; vs_in = 0; fid_in = 0;
    #1; check_all(); advance();
    chk("R5 v over h line", int'(v_pos), c_f2);
    chk("R12 field after load", int'(field), 1);
    run_phase(2 * c_len, 1'b0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule